// File: doc/BRIEF.md
# Reset Source Controller

This block gathers the reset requests of a chip. It takes three sources: a supply monitor, an active-low external reset pin, and a missing-clock detector. It merges them into one synchronous, active-low system reset with a fixed hold-off after the last request goes away. The pin passes through a synchronizer and a glitch filter. The supply monitor is gated twice: it must be switched on in its control register, and it must also be chosen as a reset source. The missing-clock source is armed by software and is masked while the device sits in a low-power state.

Two byte-wide registers sit behind a small read/write port. Address 0 is the monitor control register. It holds the enable bit and two live comparator status bits. Address 1 is the source register. It holds the monitor selection bit, the missing-clock arm bit and three cause flags. The cause flags record which source started the most recent reset, and the reset they describe does not clear them. Only the power-on input clears them. The configuration bits return to their reset values whenever the system reset is active.

Top module: `reset_hub`

## Requirements
- R1: While por_n is low, every register is cleared to its reset value. System reset stays asserted (sys_rst_n = 0) for 16 cycles after por_n rises and then releases. After that, address 0 reads 0xE0 when both comparators report "above", and address 1 reads 0x00.
- R2: Address 0 has this layout. Bit 7 is the monitor enable: it can be read and written, and it resets to 1. Bit 6 reads sup_above_rst live, and bit 5 reads sup_above_warn live; both are 1 when the supply is above the threshold.
- R3: Bits 4:0 of address 0 always read 0, and writing ones to them changes nothing.
- R4: The supply monitor asserts system reset while sup_above_rst = 0 only if the enable (address 0 bit 7) is 1 and the selection (address 1 bit 1, which resets to 0) is 1. Any other combination has no effect.
- R5: The pin is accepted only after its synchronized level has been low for 4 consecutive cycles. sys_rst_n falls 6 cycles after the pin falls. A low pulse of 3 cycles or fewer causes no reset.
- R6: The pin reset works the same way while low_power = 1.
- R7: After the last active request is removed, sys_rst_n stays low for a further 16 cycles. For the pin, sys_rst_n rises 19 cycles after the pin rises.
- R8: Address 1 holds the cause flags: bit 0 for the pin, bit 2 for the missing-clock detector and bit 3 for the supply monitor. Each new reset sets only the flag of its cause and clears the others. If causes arrive together, the pin wins over the missing-clock detector, which wins over the monitor. System reset leaves the flags intact; por_n clears them.
- R9: Writing 1 to address 1 bit 2 arms the missing-clock detector. Once armed, clk_missing = 1 asserts system reset, but not while low_power = 1. The armed state is restored when low_power returns to 0.
- R10: While system reset is active, the enable returns to 1, the selection and the arm bit return to 0, and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| sup_above_rst | input | 1 | Comparator: supply above the reset threshold |
| sup_above_warn | input | 1 | Comparator: supply above the early-warning threshold |
| clk_missing | input | 1 | Missing-clock detector timeout |
| low_power | input | 1 | Device is in suspend or sleep |
| reg_addr | input | 1 | Register select: 0 monitor control, 1 source |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The monitor and missing-clock requests act on sys_rst_n combinationally, so the bench samples 1 ns after the driving falling edge. It expects sys_rst_n to rise after 16 more rising edges, because the first edge clears the source's own configuration. The pin result is due 6 edges after the pin falls and 19 edges after it rises. The bench counts falling edges from the stimulus and checks one cycle before each expected edge as well as at the edge itself. Register reads are combinational and are taken 1 ns after the address is set, while flags and configuration are read only once the reset hold has expired.

// File: rtl/reset_hub_pkg.sv
// Shared register bit positions and types for the reset source controller.
// Assumes 8-bit registers and a one-bit register address.
package reset_hub_pkg;
    localparam int REG_W        = 8;
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_RST_BIT  = 6;
    localparam int CTL_WARN_BIT = 5;
    localparam int SRC_PIN_BIT  = 0;
    localparam int SRC_SEL_BIT  = 1;
    localparam int SRC_MCD_BIT  = 2;
    localparam int SRC_MON_BIT  = 3;

    typedef enum logic {REG_CTL = 1'b0, REG_SRC = 1'b1} reg_sel_e;

    typedef struct packed {
        logic mon;
        logic mcd;
        logic pin;
    } cause_t;
endpackage

// File: rtl/rh_pin_filter.sv
// External reset pin conditioner: a SYNC_STAGES-deep synchronizer followed by
// a filter that accepts the pin only after FILT consecutive low samples.
// Assumes SYNC_STAGES >= 2 and FILT >= 2. Only power-on clears it.
module rh_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT        = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic req
);
    localparam int CW = $clog2(FILT + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   pin_sync;

    // Shift the raw pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign pin_sync = sync_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturating at FILT.
    always_ff @(posedge clk) begin
        if (!por_n)                    low_cnt <= '0;
        else if (pin_sync)             low_cnt <= '0;
        else if (low_cnt != CW'(FILT)) low_cnt <= low_cnt + 1'b1;
    end

    assign req = (low_cnt == CW'(FILT));

    p_accept_r5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(req) |-> ($past(low_cnt) == CW'(FILT - 1)) && $past(!pin_sync));
endmodule

// File: rtl/rh_stretch.sv
// Reset hold-off timer: keeps the reset active while any request is present
// and for HOLD cycles after the last one disappears. Power-on preloads the
// timer so the system reset is also stretched after power-on.
module rh_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic req,
    output logic active,
    output logic new_event
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] hold_cnt;

    // Reload on request or power-on, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!por_n || req)        hold_cnt <= CW'(HOLD);
        else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
    end

    assign active    = req || (hold_cnt != '0);
    assign new_event = req && (hold_cnt == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(req) |-> active);
endmodule

// File: rtl/rh_regs.sv
// Register file: monitor control at REG_CTL, source selection and cause
// flags at REG_SRC. Configuration is reset by power-on or system reset;
// the cause flags only by power-on. Reads are combinational.
module rh_regs
    import reset_hub_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             in_rst,
    input  logic             new_event,
    input  cause_t           cause,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             sup_rst_ok,
    input  logic             sup_warn_ok,
    output logic [REG_W-1:0] rdata,
    output logic             mon_en,
    output logic             mon_sel,
    output logic             mcd_en
);
    cause_t flags;
    cause_t winner;
    logic   unused_wbits;

    assign unused_wbits = ^{wdata[REG_W-1:4], wdata[0]};

    // Configuration bits: reset values during any reset, else software writes.
    always_ff @(posedge clk) begin
        if (!por_n || in_rst) begin
            mon_en  <= 1'b1;
            mon_sel <= 1'b0;
            mcd_en  <= 1'b0;
        end else if (wr_en) begin
            if (reg_sel_e'(addr) == REG_CTL) begin
                mon_en <= wdata[CTL_EN_BIT];
            end else begin
                mon_sel <= wdata[SRC_SEL_BIT];
                mcd_en  <= wdata[SRC_MCD_BIT];
            end
        end
    end

    // Pick a single cause: pin over missing clock over supply monitor.
    always_comb begin
        winner = '0;
        if (cause.pin)      winner.pin = 1'b1;
        else if (cause.mcd) winner.mcd = 1'b1;
        else if (cause.mon) winner.mon = 1'b1;
    end

    // Cause flags: captured at the start of each reset, kept otherwise.
    always_ff @(posedge clk) begin
        if (!por_n)         flags <= '0;
        else if (new_event) flags <= winner;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (reg_sel_e'(addr) == REG_CTL) begin
            rdata[CTL_EN_BIT]   = mon_en;
            rdata[CTL_RST_BIT]  = sup_rst_ok;
            rdata[CTL_WARN_BIT] = sup_warn_ok;
        end else begin
            rdata[SRC_PIN_BIT] = flags.pin;
            rdata[SRC_SEL_BIT] = mon_sel;
            rdata[SRC_MCD_BIT] = flags.mcd;
            rdata[SRC_MON_BIT] = flags.mon;
        end
    end

    p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(flags));
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        !new_event |=> $stable(flags));
    p_cfg_reset_r10: assert property (@(posedge clk) disable iff (!por_n)
        in_rst |=> (mon_en && !mon_sel && !mcd_en));
    p_reserved_r3: assert property (@(posedge clk) disable iff (!por_n)
        (addr == 1'b0) |-> (rdata[4:0] == 5'b0));
endmodule

// File: rtl/reset_hub.sv
// Reset source controller top: combines the filtered pin, the gated supply
// monitor and the gated missing-clock detector into one stretched,
// active-low system reset. Assumes all inputs except the pin are already
// synchronous to clk.
module reset_hub
    import reset_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PIN_FILT    = 4,
    parameter int HOLD        = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin_n,
    input  logic       sup_above_rst,
    input  logic       sup_above_warn,
    input  logic       clk_missing,
    input  logic       low_power,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sys_rst_n
);
    logic   pin_req;
    logic   mon_req;
    logic   mcd_req;
    logic   any_req;
    logic   rst_active;
    logic   new_event;
    logic   mon_en;
    logic   mon_sel;
    logic   mcd_en;
    cause_t cause;

    rh_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT(PIN_FILT)) u_pin (
        .clk   (clk),
        .por_n (por_n),
        .pin_n (rst_pin_n),
        .req   (pin_req)
    );

    // Gate each source with its own enables.
    always_comb begin
        mon_req   = mon_en && mon_sel && !sup_above_rst;
        mcd_req   = mcd_en && !low_power && clk_missing;
        any_req   = pin_req || mon_req || mcd_req;
        cause.pin = pin_req;
        cause.mcd = mcd_req;
        cause.mon = mon_req;
    end

    rh_stretch #(.HOLD(HOLD)) u_hold (
        .clk       (clk),
        .por_n     (por_n),
        .req       (any_req),
        .active    (rst_active),
        .new_event (new_event)
    );

    assign sys_rst_n = !rst_active;

    rh_regs u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .in_rst      (rst_active),
        .new_event   (new_event),
        .cause       (cause),
        .wr_en       (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .sup_rst_ok  (sup_above_rst),
        .sup_warn_ok (sup_above_warn),
        .rdata       (reg_rdata),
        .mon_en      (mon_en),
        .mon_sel     (mon_sel),
        .mcd_en      (mcd_en)
    );

    p_gate_r4: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !sup_above_rst) |-> !(mon_en && mon_sel));
    p_pin_any_mode_r6: assert property (@(posedge clk) disable iff (!por_n)
        pin_req |-> !sys_rst_n);
endmodule

// File: tb/sim_reset_hub.sv
// Self-checking bench for reset_hub: sweeps monitor gating, pin pulse
// lengths, missing-clock masking and flag capture.
module sim_reset_hub;
    logic       clk = 1'b0;
    logic       por_n, rst_pin_n, sup_above_rst, sup_above_warn;
    logic       clk_missing, low_power, reg_addr, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sys_rst_n;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    reset_hub u0 (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
        .sup_above_rst(sup_above_rst), .sup_above_warn(sup_above_warn),
        .clk_missing(clk_missing), .low_power(low_power),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       seen;
        por_n = 1'b0; rst_pin_n = 1'b1; sup_above_rst = 1'b1; sup_above_warn = 1'b1;
        clk_missing = 1'b0; low_power = 1'b0; reg_addr = 1'b0; reg_wr = 1'b0;
        reg_wdata = 8'h00;
        negs(3);
        por_n = 1'b1;
        // R1: reset held for 16 edges after power-on release
        negs(15); check("R1 hold", sys_rst_n, 0);
        negs(1);  check("R1 release", sys_rst_n, 1);
        rd(1'b0, d); check("R1 ctl", d, 8'hE0);
        rd(1'b1, d); check("R1 src", d, 8'h00);

        // R2: status bits follow comparators
        for (int c = 0; c < 4; c++) begin
            sup_above_rst = c[1]; sup_above_warn = c[0];
            rd(1'b0, d);
            check("R2 status", d, 8'h80 | (c[1] << 6) | (c[0] << 5));
        end
        sup_above_rst = 1'b1; sup_above_warn = 1'b1;
        wr(1'b0, 8'h00); rd(1'b0, d); check("R2 enable off", d, 8'h60);
        // R3: reserved bits ignored
        wr(1'b0, 8'h1F); rd(1'b0, d); check("R3 reserved", d, 8'h60);
        wr(1'b0, 8'hFF); rd(1'b0, d); check("R3 enable on", d, 8'hE0);

        // R4: monitor gating sweep, R7 hold, R8 flag, R10 config reset
        for (int en = 0; en < 2; en++) begin
            for (int sel = 0; sel < 2; sel++) begin
                wr(1'b0, 8'(en << 7));
                wr(1'b1, 8'(sel << 1));
                @(negedge clk); sup_above_rst = 1'b0; #1;
                check("R4 gate", sys_rst_n, (en == 1 && sel == 1) ? 0 : 1);
                if (en == 1 && sel == 1) begin
                    negs(16); check("R7 monitor hold", sys_rst_n, 0);
                    negs(1);  check("R7 monitor release", sys_rst_n, 1);
                    sup_above_rst = 1'b1;
                    rd(1'b1, d); check("R8 monitor flag", d, 8'h08);
                    rd(1'b0, d); check("R10 enable restored", d, 8'hE0);
                end else begin
                    negs(20); check("R4 no reset", sys_rst_n, 1);
                    sup_above_rst = 1'b1;
                end
            end
        end

        // R5: pulse length sweep
        for (int len = 1; len <= 6; len++) begin
            @(negedge clk); rst_pin_n = 1'b0;
            seen = 1'b0;
            for (int i = 0; i < len; i++) begin
                @(negedge clk); #1; if (!sys_rst_n) seen = 1'b1;
            end
            rst_pin_n = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk); #1; if (!sys_rst_n) seen = 1'b1;
            end
            check("R5 filter", seen, (len >= 4) ? 1 : 0);
            negs(25);
            rd(1'b1, d);
            check("R8 pin flag", d, (len >= 4) ? 8'h01 : 8'h08);
        end

        // R6/R5/R7: exact pin latency while in low power
        low_power = 1'b1;
        @(negedge clk); rst_pin_n = 1'b0;
        negs(5); check("R5 before accept", sys_rst_n, 1);
        negs(1); check("R6 pin in low power", sys_rst_n, 0);
        negs(4); rst_pin_n = 1'b1;
        negs(18); check("R7 pin hold", sys_rst_n, 0);
        negs(1);  check("R7 pin release", sys_rst_n, 1);
        rd(1'b1, d); check("R8 pin flag low power", d, 8'h01);

        // R9: missing clock masked in low power, restored after
        wr(1'b1, 8'h04);
        @(negedge clk); clk_missing = 1'b1;
        negs(5); check("R9 masked", sys_rst_n, 1);
        low_power = 1'b0; #1;
        check("R9 restored", sys_rst_n, 0);
        // R10: write during reset ignored
        wr(1'b0, 8'h00);
        clk_missing = 1'b0;
        negs(25);
        rd(1'b0, d); check("R10 write ignored", d, 8'hE0);
        rd(1'b1, d); check("R9 mcd flag", d, 8'h04);

        // R8: missing clock wins over monitor
        wr(1'b1, 8'h06);
        @(negedge clk); clk_missing = 1'b1; sup_above_rst = 1'b0; #1;
        check("R8 both request", sys_rst_n, 0);
        @(negedge clk); clk_missing = 1'b0; sup_above_rst = 1'b1;
        negs(25);
        rd(1'b1, d); check("R8 priority", d, 8'h04);

        // R1: power-on clears flags
        @(negedge clk); por_n = 1'b0;
        negs(2); por_n = 1'b1;
        negs(17);
        rd(1'b1, d); check("R1 flags cleared", d, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule